// File: doc/BRIEF.md
# Serial Character Echo Terminal

This block turns a serial port into an echoing terminal. Characters arrive on a single asynchronous receive line. Each one starts with a low start bit, carries eight data bits with the least significant bit first, and ends with a high stop bit. Every completed character is sent straight back on the transmit line in the same format. The bit period is a fixed number of clock cycles, found by integer division of the clock frequency by the baud rate. The defaults give 434 cycles per bit, for about 115,200 baud from 50 MHz.

The receive line first passes through a two-stage synchronizer. While the receiver is idle, a low level on the synchronized line starts a character. The receiver waits half a bit period and checks again that the line is still low. It then samples each data bit in the middle of its period. At the middle of the stop bit the byte is complete. It goes into a single-entry holding register and raises a pending flag. Only the receiver sets this flag, and only the transmitter clears it. The transmitter takes a private copy of the held byte and shifts it out. If a new byte completes while the transmitter is still busy, it overwrites the held one, so the transmitter always sends the most recent complete byte next. The line is not checked for errors.

Top module: `uart_echo`

## Requirements
- R1: TXD is 1 while rst_n is low, and it stays 1 whenever no echo is in progress.
- R2: A well-formed character is echoed with the same data byte. The echo has a start bit of 0, eight data bits with the least significant bit first, and a stop bit of 1. Each bit lasts CLK_HZ/BAUD clock cycles (434 at the defaults).
- R3: For a single isolated character, the echo's start bit begins exactly 9*B + B/2 + 5 clock cycles after the first falling edge of RXD, where B is the bit period. The 5 cycles are two synchronizer stages, start detection, the handoff register and the transmit load.
- R4: A low pulse on RXD that has ended before the half-bit check produces no echo. The next well-formed character is then received normally.
- R5: The stop bit value is not checked. A character whose stop bit is 0 is still echoed, exactly once, with its data.
- R6: A byte that completes while the transmitter is busy overwrites the held byte. Under a burst faster than the echo rate, the echoed bytes are an in-order subset of the bytes sent, fewer than were sent, and the last echo is the last byte sent.
- R7: Characters sent back to back with full-length stop bits are all echoed, in the order they were received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Asynchronous serial receive line, idle high |
| txd | output | 1 | Serial transmit line carrying the echo, idle high |

## Verification
Eight bytes are sent back to back: alternating bits, all zeros, all ones, single-bit values at each end and mixed patterns. These show that bit order and sampling points are correct and that no byte is lost at the normal rate. A single isolated character measures the exact cycle at which the echo starts. A short low glitch and a character with a low stop bit separate the half-bit start check from the unchecked stop bit. A burst of characters with shortened stop bits makes the transmitter fall behind. This exposes the overwrite rule: echoes stay in order, some bytes are dropped, and the newest byte always comes out last.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

endpackage

// File: rtl/uart_echo_sync.sv
module uart_echo_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sync_d;
    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = din;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {STAGES{RESET_VAL}};
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/uart_echo_rx.sv
module uart_echo_rx
    import uart_echo_pkg::*;
#(
    parameter int BIT_CYCLES = 434,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] byte_out,
    output logic                 byte_done
);

    localparam int CNT_W = $clog2(BIT_CYCLES);
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(BIT_CYCLES - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(BIT_CYCLES / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e            st;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [DATA_BITS-1:0] sh;
        logic                 done;
    } rx_regs_t;

    localparam rx_regs_t RX_RESET = '{
        st:   RX_IDLE,
        cnt:  '0,
        idx:  '0,
        sh:   '0,
        done: 1'b0
    };

    rx_regs_t rx_d;
    rx_regs_t rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        rx_d.cnt  = rx_q.cnt + 1'b1;
        unique case (rx_q.st)
            RX_IDLE: begin
                rx_d.cnt = '0;
                if (!rx_line) rx_d.st = RX_START;
            end
            RX_START: begin
                // re-check the start bit half a period in
                if (rx_q.cnt == HALF_LAST) begin
                    rx_d.cnt = '0;
                    rx_d.idx = '0;
                    rx_d.st  = rx_line ? RX_IDLE : RX_DATA;
                end
            end
            RX_DATA: begin
                if (rx_q.cnt == BIT_LAST) begin
                    rx_d.cnt = '0;
                    rx_d.sh  = {rx_line, rx_q.sh[DATA_BITS-1:1]};
                    if (rx_q.idx == IDX_LAST) rx_d.st  = RX_STOP;
                    else                      rx_d.idx = rx_q.idx + 1'b1;
                end
            end
            RX_STOP: begin
                // stop level is not examined
                if (rx_q.cnt == BIT_LAST) begin
                    rx_d.cnt  = '0;
                    rx_d.st   = RX_IDLE;
                    rx_d.done = 1'b1;
                end
            end
            default: rx_d = RX_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= RX_RESET;
        else        rx_q <= rx_d;
    end

    assign byte_out  = rx_q.sh;
    assign byte_done = rx_q.done;

endmodule

// File: rtl/uart_echo_mbox.sv
module uart_echo_mbox #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_byte,
    input  logic                 take,
    output logic                 pending,
    output logic [DATA_BITS-1:0] held_byte
);

    typedef struct packed {
        logic                 pend;
        logic [DATA_BITS-1:0] held;
    } mbox_regs_t;

    mbox_regs_t mb_d;
    mbox_regs_t mb_q;

    always_comb begin
        mb_d = mb_q;
        if (load) begin
            // a new byte always wins, replacing anything still held
            mb_d.held = load_byte;
            mb_d.pend = 1'b1;
        end else if (take) begin
            mb_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mb_q <= '0;
        else        mb_q <= mb_d;
    end

    assign pending   = mb_q.pend;
    assign held_byte = mb_q.held;

endmodule

// File: rtl/uart_echo_tx.sv
module uart_echo_tx
    import uart_echo_pkg::*;
#(
    parameter int BIT_CYCLES = 434,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pending,
    input  logic [DATA_BITS-1:0] held_byte,
    output logic                 take,
    output logic                 busy,
    output logic                 tx_line
);

    localparam int CNT_W = $clog2(BIT_CYCLES);
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BIT_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    typedef struct packed {
        tx_state_e            st;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [DATA_BITS-1:0] sh;
        logic                 line;
    } tx_regs_t;

    localparam tx_regs_t TX_RESET = '{
        st:   TX_IDLE,
        cnt:  '0,
        idx:  '0,
        sh:   '0,
        line: 1'b1
    };

    tx_regs_t tx_d;
    tx_regs_t tx_q;
    logic     take_w;

    always_comb begin
        tx_d   = tx_q;
        take_w = 1'b0;
        tx_d.cnt = tx_q.cnt + 1'b1;
        unique case (tx_q.st)
            TX_IDLE: begin
                tx_d.cnt  = '0;
                tx_d.line = 1'b1;
                if (pending) begin
                    take_w    = 1'b1;
                    tx_d.sh   = held_byte;
                    tx_d.st   = TX_START;
                    tx_d.line = 1'b0;
                end
            end
            TX_START: begin
                if (tx_q.cnt == BIT_LAST) begin
                    tx_d.cnt  = '0;
                    tx_d.idx  = '0;
                    tx_d.st   = TX_DATA;
                    tx_d.line = tx_q.sh[0];
                end
            end
            TX_DATA: begin
                if (tx_q.cnt == BIT_LAST) begin
                    tx_d.cnt = '0;
                    if (tx_q.idx == IDX_LAST) begin
                        tx_d.st   = TX_STOP;
                        tx_d.line = 1'b1;
                    end else begin
                        tx_d.idx  = tx_q.idx + 1'b1;
                        tx_d.sh   = {1'b0, tx_q.sh[DATA_BITS-1:1]};
                        tx_d.line = tx_q.sh[1];
                    end
                end
            end
            TX_STOP: begin
                if (tx_q.cnt == BIT_LAST) begin
                    tx_d.cnt = '0;
                    tx_d.st  = TX_IDLE;
                end
            end
            default: tx_d = TX_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= TX_RESET;
        else        tx_q <= tx_d;
    end

    assign take    = take_w;
    assign busy    = (tx_q.st != TX_IDLE);
    assign tx_line = tx_q.line;

endmodule

// File: rtl/uart_echo.sv
module uart_echo #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BAUD        = 115_200,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic txd
);

    localparam int BIT_CYCLES = CLK_HZ / BAUD;

    logic                 rx_sync;
    logic [DATA_BITS-1:0] rx_byte;
    logic                 rx_done;
    logic                 mb_pending;
    logic [DATA_BITS-1:0] mb_byte;
    logic                 tx_take;
    logic                 tx_busy;

    uart_echo_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_sync)
    );

    uart_echo_rx #(
        .BIT_CYCLES (BIT_CYCLES),
        .DATA_BITS  (DATA_BITS)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_sync),
        .byte_out  (rx_byte),
        .byte_done (rx_done)
    );

    uart_echo_mbox #(
        .DATA_BITS (DATA_BITS)
    ) u_mbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rx_done),
        .load_byte (rx_byte),
        .take      (tx_take),
        .pending   (mb_pending),
        .held_byte (mb_byte)
    );

    uart_echo_tx #(
        .BIT_CYCLES (BIT_CYCLES),
        .DATA_BITS  (DATA_BITS)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (mb_pending),
        .held_byte (mb_byte),
        .take      (tx_take),
        .busy      (tx_busy),
        .tx_line   (txd)
    );

endmodule

// File: rtl/uart_echo_chk.sv
module uart_echo_chk (
    input logic clk,
    input logic rst_n,
    input logic txd,
    input logic tx_busy,
    input logic rx_done,
    input logic take,
    input logic pending
);

    // R1
    txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R6
    done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> pending);

    // R6
    take_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pending);

    // R6
    take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !tx_busy);

endmodule

bind uart_echo uart_echo_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .txd     (txd),
    .tx_busy (tx_busy),
    .rx_done (rx_done),
    .take    (tx_take),
    .pending (mb_pending)
);

// File: tb/tb_uart_echo.sv
module tb_uart_echo;

    localparam int CLK_HZ = 1_600_000;
    localparam int BAUD   = 100_000;
    localparam int BITP   = CLK_HZ / BAUD;  // 16 cycles per bit
    localparam int HALF   = BITP / 2;
    localparam int LAT    = 9 * BITP + HALF + 5;
    localparam int NBURST = 40;

    // {stimulus byte, expected echo byte}
    localparam logic [15:0] VEC [8] = '{
        16'h5555, 16'h0000, 16'hFFFF, 16'h0101,
        16'h8080, 16'hA5A5, 16'h3C3C, 16'h4848
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic txd;

    int cyc = 0;
    int n_checks = 0;
    int n_err = 0;
    int t_send = 0;

    logic [7:0] echo_log [128];
    int         echo_t   [128];
    int         n_echo = 0;

    uart_echo #(
        .CLK_HZ (CLK_HZ),
        .BAUD   (BAUD)
    ) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .rxd   (rxd),
        .txd   (txd)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // decode frames on txd, sampling mid-bit at falling clock edges
    always begin : mon
        int         t0;
        logic [7:0] b;
        @(negedge clk);
        if (rst_n && txd === 1'b0) begin
            t0 = cyc;
            repeat (HALF) @(negedge clk);
            check(txd === 1'b0, "R2 echo start bit low", int'(txd), 0);
            for (int k = 0; k < 8; k++) begin
                repeat (BITP) @(negedge clk);
                b[k] = txd;
            end
            repeat (BITP) @(negedge clk);
            check(txd === 1'b1, "R2 echo stop bit high", int'(txd), 1);
            if (n_echo < 128) begin
                echo_log[n_echo] = b;
                echo_t[n_echo]   = t0;
            end
            n_echo++;
        end
    end

    task automatic send_char(input logic [7:0] b, input int stop_cycles, input logic stop_val);
        @(posedge clk); #1;
        t_send = cyc;
        rxd = 1'b0;
        for (int k = 0; k < 8; k++) begin
            repeat (BITP) @(posedge clk); #1;
            rxd = b[k];
        end
        repeat (BITP) @(posedge clk); #1;
        rxd = stop_val;
        repeat (stop_cycles) @(posedge clk); #1;
        rxd = 1'b1;
    endtask

    task automatic wait_echo(input int target, input int limit);
        for (int i = 0; i < limit; i++) begin
            if (n_echo >= target) break;
            @(negedge clk);
        end
    endtask

    initial begin : wd
        repeat (100_000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : main
        int base;
        int ptr;
        bit order_ok;
        logic [7:0] sent [NBURST];

        // R1: line high during reset
        repeat (5) @(negedge clk);
        check(txd === 1'b1, "R1 txd during reset", int'(txd), 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check(txd === 1'b1, "R1 txd idle after reset", int'(txd), 1);
        check(n_echo == 0, "R1 no echo while idle", n_echo, 0);

        // R7 / R2: vector table sent back to back
        base = n_echo;
        for (int i = 0; i < 8; i++) send_char(VEC[i][15:8], BITP - 1, 1'b1);
        wait_echo(base + 8, 20 * BITP);
        check(n_echo - base == 8, "R7 all back-to-back bytes echoed", n_echo - base, 8);
        for (int i = 0; i < 8; i++)
            check(echo_log[base + i] == VEC[i][7:0], "R2 R7 echoed byte",
                  int'(echo_log[base + i]), int'(VEC[i][7:0]));
        repeat (3 * BITP) @(negedge clk);

        // R3: exact echo latency for an isolated character
        base = n_echo;
        send_char(8'hC3, BITP - 1, 1'b1);
        wait_echo(base + 1, 20 * BITP);
        check(n_echo == base + 1, "R3 single echo", n_echo - base, 1);
        check(echo_t[base] - t_send == LAT, "R3 echo start latency", echo_t[base] - t_send, LAT);
        check(echo_log[base] == 8'hC3, "R3 echo data", int'(echo_log[base]), 'hC3);
        repeat (3 * BITP) @(negedge clk);

        // R4: short glitch gives no echo, receiver recovers
        base = n_echo;
        @(posedge clk); #1;
        rxd = 1'b0;
        repeat (3) @(posedge clk); #1;
        rxd = 1'b1;
        repeat (25 * BITP) @(negedge clk);
        check(n_echo == base, "R4 glitch not echoed", n_echo - base, 0);
        check(txd === 1'b1, "R4 txd idle after glitch", int'(txd), 1);
        send_char(8'h6D, BITP - 1, 1'b1);
        wait_echo(base + 1, 20 * BITP);
        check(n_echo == base + 1 && echo_log[base] == 8'h6D, "R4 byte after glitch",
              int'(echo_log[base]), 'h6D);
        repeat (3 * BITP) @(negedge clk);

        // R5: low stop bit still echoed once
        base = n_echo;
        send_char(8'h96, BITP - 1, 1'b0);
        repeat (25 * BITP) @(negedge clk);
        check(n_echo == base + 1, "R5 one echo for low stop bit", n_echo - base, 1);
        check(echo_log[base] == 8'h96, "R5 data kept despite low stop", int'(echo_log[base]), 'h96);
        repeat (3 * BITP) @(negedge clk);

        // R6: burst with short stop bits overruns the transmitter
        base = n_echo;
        for (int i = 0; i < NBURST; i++) begin
            sent[i] = 8'((i * 37 + 11) & 8'hFF);
            send_char(sent[i], HALF + 1, 1'b1);
        end
        repeat (25 * BITP) @(negedge clk);
        check(n_echo - base < NBURST, "R6 some bytes overwritten", n_echo - base, NBURST - 1);
        check(n_echo - base > 0, "R6 burst produced echoes", n_echo - base, 1);
        order_ok = 1'b1;
        ptr = 0;
        for (int e = base; e < n_echo; e++) begin
            while (ptr < NBURST && sent[ptr] != echo_log[e]) ptr++;
            if (ptr >= NBURST) order_ok = 1'b0;
            else ptr++;
        end
        check(order_ok, "R6 echoes are in-order subset", int'(order_ok), 1);
        check(echo_log[n_echo - 1] == sent[NBURST - 1], "R6 last echo is newest byte",
              int'(echo_log[n_echo - 1]), int'(sent[NBURST - 1]));
        check(txd === 1'b1, "R1 txd idle after burst", int'(txd), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule